// File: doc/BRIEF.md
# Double Bus Fault Detector

This block watches the exception state of a processor core and decides when a bus error must be fatal. In normal running, a bus error that is not part of a retry raises a one-cycle request for bus error exception processing. The sequencer outside the block answers with an exception-start pulse, which marks exception handling as in progress. If a second bus error arrives before the next instruction-start pulse, the block halts the core. It also halts the core when a bus error hits a vector table fetch during the reset sequence. Once halted, only an external reset brings it back.

A bus error raised together with a retry request is a retry. It requests no exception and can never halt the core, however many times external logic repeats it. The block is a small state machine with four states. ST_VECFETCH is the reset sequence before the first instruction. ST_RUN is normal execution. ST_EXCEPT means exception processing is in progress. ST_HALTED is the latched double fault.

The transitions are:
- VECFETCH_TO_RUN on instruction start.
- VECFETCH_TO_HALTED on a bus error, not a retry, while a vector fetch is flagged.
- RUN_TO_EXCEPT on exception start.
- EXCEPT_TO_RUN on instruction start.
- EXCEPT_TO_HALTED on a bus error that is not a retry.
- ANY_TO_VECFETCH on reset.

Top module: `dbf_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the block enters ST_VECFETCH. After that edge, `halt_o`, `berr_exc_req` and `exc_busy` are all 0.
- R2: In ST_RUN, `bus_err`=1 with `retry_req`=0 makes `berr_exc_req` 1 for exactly the following cycle. It does not assert `halt_o`.
- R3: In ST_RUN, `exc_begin` makes `exc_busy` 1 from the next cycle (ST_EXCEPT). In ST_EXCEPT, `insn_begin` makes `exc_busy` 0 from the next cycle (ST_RUN).
- R4: In ST_EXCEPT, `bus_err`=1 with `retry_req`=0 makes `halt_o` 1 and `exc_busy` 0 from the next cycle. This holds even when `insn_begin` is high in the same cycle.
- R5: In ST_VECFETCH, a bus error that is not a retry halts the core from the next cycle if `vec_fetch`=1. With `vec_fetch`=0 it has no effect: no request and no halt. `insn_begin` moves ST_VECFETCH to ST_RUN. `exc_begin` is ignored in ST_VECFETCH.
- R6: Whenever `retry_req`=1, `bus_err` is treated as a retry in every state. It raises no request, causes no halt and causes no state change, for any number of consecutive cycles.
- R7: Once `halt_o` is 1, it stays 1 every cycle until reset, whatever the other inputs do. `berr_exc_req` and `exc_busy` stay 0 during that time.
- R8: Reset from ST_HALTED clears `halt_o` and re-enters ST_VECFETCH. A bus error during a flagged vector fetch then halts the core again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | External reset, synchronous, active high |
| bus_err | input | 1 | Bus error strobe for the current cycle |
| retry_req | input | 1 | Current cycle is a retry; wins over bus_err |
| vec_fetch | input | 1 | Reset sequence is fetching from the vector table |
| exc_begin | input | 1 | Exception processing start pulse |
| insn_begin | input | 1 | Instruction start pulse |
| halt_o | output | 1 | Registered halt, held while double-faulted |
| berr_exc_req | output | 1 | One-cycle request for bus error exception processing |
| exc_busy | output | 1 | Exception processing in progress |

## Verification
The bench targets several corner cases, each tied to a specific faulty behaviour:
- A bus error that coincides with instruction start inside an exception. A design that let the instruction start win would return to running instead of halting.
- A bus error paired with retry, repeated over many cycles in both running and exception states. Giving bus error the priority would either request an exception or halt the core on a retry.
- A bus error in the reset phase, tried both with and without the vector fetch flag. This exposes a detector that ignores the flag or treats every reset-phase error as fatal.
- A halted core hit with every input at once. This catches a halt that leaks away, or one that still issues requests.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
    typedef enum logic [1:0] {
        ST_VECFETCH = 2'd0,
        ST_RUN      = 2'd1,
        ST_EXCEPT   = 2'd2,
        ST_HALTED   = 2'd3
    } dbf_state_t;
endpackage

// File: rtl/dbf_qualify.sv
// Splits the raw bus error strobe into qualified events; retry always wins.
module dbf_qualify (
    input  logic bus_err,
    input  logic retry_req,
    input  logic vec_fetch,
    output logic live_err,
    output logic vec_err
);
    always_comb begin
        live_err = bus_err & ~retry_req;
        vec_err  = bus_err & ~retry_req & vec_fetch;
    end
endmodule

// File: rtl/dbf_fsm.sv
module dbf_fsm
    import dbf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       live_err,
    input  logic       vec_err,
    input  logic       exc_begin,
    input  logic       insn_begin,
    output dbf_state_t state,
    output dbf_state_t state_nx
);
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_VECFETCH: begin
                if (vec_err)         state_nx = ST_HALTED;   // VECFETCH_TO_HALTED
                else if (insn_begin) state_nx = ST_RUN;      // VECFETCH_TO_RUN
            end
            ST_RUN: begin
                if (exc_begin)       state_nx = ST_EXCEPT;   // RUN_TO_EXCEPT
            end
            ST_EXCEPT: begin
                if (live_err)        state_nx = ST_HALTED;   // EXCEPT_TO_HALTED
                else if (insn_begin) state_nx = ST_RUN;      // EXCEPT_TO_RUN
            end
            ST_HALTED: begin
                state_nx = ST_HALTED;
            end
            default: state_nx = ST_VECFETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_VECFETCH;                       // ANY_TO_VECFETCH
        else     state <= state_nx;
    end
endmodule

// File: rtl/dbf_outreg.sv
module dbf_outreg
    import dbf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  dbf_state_t state,
    input  dbf_state_t state_nx,
    input  logic       live_err,
    output logic       halt_o,
    output logic       berr_exc_req,
    output logic       exc_busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            halt_o       <= 1'b0;
            berr_exc_req <= 1'b0;
            exc_busy     <= 1'b0;
        end else begin
            halt_o       <= (state_nx == ST_HALTED);
            berr_exc_req <= (state == ST_RUN) && live_err;
            exc_busy     <= (state_nx == ST_EXCEPT);
        end
    end
endmodule

// File: rtl/dbf_detector.sv
module dbf_detector
    import dbf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_err,
    input  logic retry_req,
    input  logic vec_fetch,
    input  logic exc_begin,
    input  logic insn_begin,
    output logic halt_o,
    output logic berr_exc_req,
    output logic exc_busy
);
    logic       live_err;
    logic       vec_err;
    dbf_state_t state;
    dbf_state_t state_nx;

    dbf_qualify u_qual (
        .bus_err   (bus_err),
        .retry_req (retry_req),
        .vec_fetch (vec_fetch),
        .live_err  (live_err),
        .vec_err   (vec_err)
    );

    dbf_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .live_err   (live_err),
        .vec_err    (vec_err),
        .exc_begin  (exc_begin),
        .insn_begin (insn_begin),
        .state      (state),
        .state_nx   (state_nx)
    );

    dbf_outreg u_out (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .state_nx     (state_nx),
        .live_err     (live_err),
        .halt_o       (halt_o),
        .berr_exc_req (berr_exc_req),
        .exc_busy     (exc_busy)
    );
endmodule

// File: rtl/dbf_checker.sv
module dbf_checker
    import dbf_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_err,
    input logic       retry_req,
    input logic       insn_begin,
    input logic       halt_o,
    input logic       berr_exc_req,
    input logic       exc_busy,
    input dbf_state_t state
);
    // R2
    run_err_req_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && bus_err && !retry_req) |=> (berr_exc_req && !halt_o));

    // R4
    second_err_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_busy && bus_err && !retry_req) |=> (halt_o && !exc_busy));

    // R4
    err_beats_insn_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_busy && bus_err && !retry_req && insn_begin) |=> halt_o);

    // R6
    retry_no_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (!halt_o && retry_req) |=> !halt_o);

    // R6
    retry_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        retry_req |=> !berr_exc_req);

    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halt_o |=> halt_o);

    // R7
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halt_o |-> (!berr_exc_req && !exc_busy));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!halt_o && !berr_exc_req && !exc_busy));
endmodule

bind dbf_detector dbf_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_err      (bus_err),
    .retry_req    (retry_req),
    .insn_begin   (insn_begin),
    .halt_o       (halt_o),
    .berr_exc_req (berr_exc_req),
    .exc_busy     (exc_busy),
    .state        (state)
);

// File: tb/dbf_detector_test.sv
`timescale 1ns/1ps
module dbf_detector_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_err = 1'b0, retry_req = 1'b0, vec_fetch = 1'b0;
    logic exc_begin = 1'b0, insn_begin = 1'b0;
    logic halt_o, berr_exc_req, exc_busy;

    int checks = 0;
    int errors = 0;
    bit armed = 1'b0;
    bit done = 1'b0;

    // reference model: 0 reset phase, 1 running, 2 exception, 3 halted
    int  mode = 0;
    bit  req_m = 1'b0;

    always #2 clk = ~clk;

    dbf_detector uut (
        .clk(clk), .rst(rst), .bus_err(bus_err), .retry_req(retry_req),
        .vec_fetch(vec_fetch), .exc_begin(exc_begin), .insn_begin(insn_begin),
        .halt_o(halt_o), .berr_exc_req(berr_exc_req), .exc_busy(exc_busy)
    );

    always @(posedge clk) begin
        bit fault;
        fault = bus_err && !retry_req;
        if (rst) begin
            mode  = 0;
            req_m = 1'b0;
        end else begin
            req_m = (mode == 1) && fault;
            if (mode == 0) begin
                if (fault && vec_fetch) mode = 3;
                else if (insn_begin)    mode = 1;
            end else if (mode == 1) begin
                if (exc_begin) mode = 2;
            end else if (mode == 2) begin
                if (fault)           mode = 3;
                else if (insn_begin) mode = 1;
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            chk("R4 model halt_o", halt_o, mode == 3);
            chk("R2 model berr_exc_req", berr_exc_req, req_m);
            chk("R3 model exc_busy", exc_busy, mode == 2);
        end
    end

    task automatic cyc(input logic b, input logic r, input logic v,
                       input logic e, input logic i);
        @(negedge clk);
        bus_err = b; retry_req = r; vec_fetch = v; exc_begin = e; insn_begin = i;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bus_err = 0; retry_req = 0; vec_fetch = 0; exc_begin = 0; insn_begin = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        armed = 1'b1;
        chk("R1 halt after reset", halt_o, 1'b0);
        chk("R1 req after reset", berr_exc_req, 1'b0);
        chk("R1 busy after reset", exc_busy, 1'b0);

        // reset phase: error without vector fetch is ignored; exc_begin ignored
        cyc(1, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R5 no halt without vec_fetch", halt_o, 1'b0);
        chk("R5 no req in reset phase", berr_exc_req, 1'b0);
        chk("R5 exc_begin ignored in reset phase", exc_busy, 1'b0);
        cyc(0, 0, 0, 0, 1);       // to running
        cyc(0, 0, 0, 0, 0);

        // running: bus error requests exception for one cycle
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R2 request raised", berr_exc_req, 1'b1);
        chk("R2 no halt", halt_o, 1'b0);
        cyc(0, 0, 0, 0, 0);
        chk("R2 request one cycle", berr_exc_req, 1'b0);

        // retries in running, many cycles
        for (int k = 0; k < 25; k++) cyc(1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R6 retry no request", berr_exc_req, 1'b0);
        chk("R6 retry no halt running", halt_o, 1'b0);

        // enter exception
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R3 busy set", exc_busy, 1'b1);
        for (int k = 0; k < 15; k++) cyc(1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R6 retry no halt in exception", halt_o, 1'b0);
        chk("R6 retry keeps exception", exc_busy, 1'b1);
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0);
        chk("R3 busy cleared", exc_busy, 1'b0);

        // exception then bus error coinciding with instruction start
        cyc(0, 0, 0, 1, 0);
        cyc(1, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0);
        chk("R4 double fault halts", halt_o, 1'b1);
        chk("R4 busy drops on halt", exc_busy, 1'b0);

        // halted: hammer all inputs
        for (int k = 0; k < 32; k++)
            cyc(k[0], k[1], k[2], k[3], k[4]);
        cyc(0, 0, 0, 0, 0);
        chk("R7 halt held", halt_o, 1'b1);
        chk("R7 no request while halted", berr_exc_req, 1'b0);
        chk("R7 no busy while halted", exc_busy, 1'b0);

        // reset out of halt, then vector fetch fault
        do_reset();
        chk("R8 reset clears halt", halt_o, 1'b0);
        cyc(1, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R6 retry during vector fetch", halt_o, 1'b0);
        cyc(1, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R5 vector fetch fault halts", halt_o, 1'b1);
        chk("R8 halt again after reset", berr_exc_req, 1'b0);

        // error and exception start in the same cycle, then second error
        do_reset();
        cyc(0, 0, 0, 0, 1);
        cyc(1, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R2 request with exc_begin", berr_exc_req, 1'b1);
        chk("R3 busy with exc_begin", exc_busy, 1'b1);
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R4 second error halts", halt_o, 1'b1);
        cyc(0, 0, 0, 0, 0);
        finish_run();
    end
endmodule